// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is a synthesizable model of a small single-clock static RAM whose common data bus can carry a read on one cycle and a write on the next, or the reverse, without an idle cycle between them. All controls are captured on the rising clock edge. Read data comes straight out of the array in the cycle that follows the capturing edge, with no extra output register. Write data arrives one clock after its address and control. It is held in a pending stage and committed on that later edge.

A 2-bit burst counter lets one loaded address serve four consecutive accesses. The counter visits the four words of the aligned group in interleaved or linear order, chosen by a static select input. Per-lane active-low write enables mask partial writes. Three chip enables, with mixed polarity, support depth expansion. An asynchronous output enable gates the bus drivers. A sleep input freezes every internal register and the array contents until it is released.

Top module: `zbs_sram`

## Requirements
- R1: Every control input is sampled on the rising clock edge. The word at the address of a read captured on edge k is driven on `dq` from just after edge k until edge k+1, with no extra register stage.
- R2: For a write captured on edge k, the data on `dq` is sampled at edge k+1. Reads and writes may alternate on every cycle with no idle cycle between them.
- R3: A read whose address matches the pending write being committed on the same edge returns that write's new data in the written lanes and the old array data in the other lanes.
- R4: `bw_n[i]` low enables writing of lane i, which is `dq[i*LANE_W +: LANE_W]`. A lane whose `bw_n` bit is high keeps its previous content.
- R5: With `adv` high, the access continues the current burst. The upper address bits stay those of the loaded address, the read/write direction stays that of the load, and `wr` is ignored. The 2-bit counter wraps after four accesses.
- R6: With `lin` low, the burst low address bits are the loaded low bits XOR the count 0,1,2,3. With `lin` high, they are the loaded low bits plus the count, modulo 4.
- R7: A load (`adv` low) starts an access only when `cs0_n` is low, `cs1` is high and `cs2_n` is low. Otherwise no access takes place and any burst in progress ends.
- R8: A continue issued after a deselecting load, or after reset, performs no access and does not drive the bus.
- R9: `oe_n` acts without a clock. While it is high, `dq` is released. Once it falls, pending read data appears on `dq` within the same cycle.
- R10: While `sleep` is high, no access is accepted, the bus is released, and the array, the burst position and any pending write are held. Normal operation resumes, from the held burst position, once `sleep` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high reset of control state |
| sleep | input | 1 | High freezes all state and ignores accesses |
| cs0_n | input | 1 | Chip enable, active low |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 continues the burst, 0 loads a new address |
| wr | input | 1 | Direction on a load: 1 write, 0 read |
| bw_n | input | LANES | Active-low write enable per byte lane |
| addr | input | ADDR_W | Word address used on a load |
| lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | LANES*LANE_W | Common tri-state data bus |

## Verification
The bench uses the default build: 64 words and two 9-bit lanes, giving an 18-bit bus. With two lanes, both single-lane masks can be exercised, and so can a forwarded read that merges one new lane with one old lane. With 64 words, bursts can be placed at aligned groups whose start offsets are 0, 1 and 2, so the interleaved and linear orders visit different addresses and the counter wrap can be seen. Because every cycle both drives and samples the shared bus, each read-after-write and write-after-read turnaround is checked at the moment it happens.

// File: rtl/zbs_pkg.sv
package zbs_pkg;

  localparam int unsigned BURST_BITS = 2;

  // Low address bits for burst step 'step' from the loaded offset 'start'.
  function automatic logic [BURST_BITS-1:0] burst_lo(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] step,
    input logic                  linear
  );
    if (linear) return BURST_BITS'(start + step);
    else        return start ^ step;
  endfunction

endpackage

// File: rtl/zbs_burst.sv
module zbs_burst
  import zbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              sel,
  input  logic              adv,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lin,
  output logic              acc_valid,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr
);

  localparam int unsigned HI_W = ADDR_W - BURST_BITS;

  logic [BURST_BITS-1:0] cnt_q;
  logic [BURST_BITS-1:0] cnt_nx;
  logic [ADDR_W-1:0]     base_q;
  logic                  live_q;
  logic                  wr_q;

  assign cnt_nx = BURST_BITS'(cnt_q + 1'b1);

  always_comb begin
    acc_valid = sel;
    acc_wr    = wr_req;
    acc_addr  = addr;
    if (adv) begin
      acc_valid = live_q;
      acc_wr    = wr_q;
      acc_addr  = {base_q[ADDR_W-1 -: HI_W],
                   burst_lo(base_q[BURST_BITS-1:0], cnt_nx, lin)};
    end
    if (hold) acc_valid = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      wr_q   <= 1'b0;
    end else if (!hold) begin
      if (!adv) begin
        live_q <= sel;
        cnt_q  <= '0;
        base_q <= addr;
        wr_q   <= wr_req;
      end else if (live_q) begin
        cnt_q <= cnt_nx;
      end
    end
  end

  // R6
  interleave_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && adv && live_q && !lin) |->
      ((acc_addr[BURST_BITS-1:0] ^ base_q[BURST_BITS-1:0]) == BURST_BITS'(cnt_q + 1'b1)));

  // R6
  linear_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && adv && live_q && lin) |->
      (BURST_BITS'(acc_addr[BURST_BITS-1:0] - base_q[BURST_BITS-1:0]) == BURST_BITS'(cnt_q + 1'b1)));

  // R7
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !adv && !sel) |=> !live_q);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && adv && live_q) |=> (cnt_q == BURST_BITS'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/zbs_wpipe.sv
module zbs_wpipe #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              take,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LANES-1:0]  bw_n,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [LANES-1:0]  commit_mask
);

  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_mask  <= '0;
    end else if (!hold) begin
      pend_valid <= take;
      pend_addr  <= acc_addr;
      pend_mask  <= ~bw_n;
    end
  end

  assign commit_en   = pend_valid && !hold;
  assign commit_addr = pend_addr;
  assign commit_mask = pend_mask;

  // R2
  commit_next_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(take && !hold) && !hold) |-> commit_en);

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(pend_valid) && $stable(pend_addr) && $stable(pend_mask)));

endmodule

// File: rtl/zbs_array.sv
module zbs_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    re,
  input  logic [ADDR_W-1:0]       raddr,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wmask,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic [LANE_W-1:0] fwd_q;
    logic              hit_q;

    always_ff @(posedge clk) begin
      if (we && wmask[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (re) begin
        rd_q  <= mem[raddr];
        fwd_q <= wdata[l*LANE_W +: LANE_W];
        hit_q <= we && wmask[l] && (waddr == raddr);
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = hit_q ? fwd_q : rd_q;

    // R3
    fwd_lane_chk: assert property (@(posedge clk) disable iff (rst)
      (re && we && wmask[l] && (waddr == raddr)) |=>
        (rdata[l*LANE_W +: LANE_W] == $past(wdata[l*LANE_W +: LANE_W])));
  end

endmodule

// File: rtl/zbs_sram.sv
module zbs_sram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic                    cs2_n,
  input  logic                    adv,
  input  logic                    wr,
  input  logic [LANES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    lin,
  input  logic                    oe_n,
  inout  wire  [LANES*LANE_W-1:0] dq
);

  localparam int unsigned DATA_W = LANES * LANE_W;

  logic              sel;
  logic              acc_valid;
  logic              acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_mask;
  logic [DATA_W-1:0] rdata;
  logic              rd_active;

  assign sel = !cs0_n && cs1 && !cs2_n;

  zbs_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst       (rst),
    .hold      (sleep),
    .sel       (sel),
    .adv       (adv),
    .wr_req    (wr),
    .addr      (addr),
    .lin       (lin),
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr)
  );

  zbs_wpipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wpipe (
    .clk         (clk),
    .rst         (rst),
    .hold        (sleep),
    .take        (acc_valid && acc_wr),
    .acc_addr    (acc_addr),
    .bw_n        (bw_n),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .commit_mask (commit_mask)
  );

  zbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .rst   (rst),
    .re    (acc_valid && !acc_wr),
    .raddr (acc_addr),
    .we    (commit_en),
    .waddr (commit_addr),
    .wmask (commit_mask),
    .wdata (dq),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst || sleep) rd_active <= 1'b0;
    else              rd_active <= acc_valid && !acc_wr;
  end

  assign dq = (rd_active && !oe_n) ? rdata : {DATA_W{1'bz}};

  // R7
  no_desel_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !adv && !sel) |=> !rd_active);

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !rd_active);

endmodule

// File: tb/zbs_sram_test.sv
`timescale 1ns/100ps
module zbs_sram_test;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned DW     = LANES * LANE_W;
  localparam logic [2:0]  SEL    = 3'b010; // {cs2_n, cs1, cs0_n}
  localparam int unsigned NV     = 14;

  // {req[3:0], en[2:0], adv, wr, bw_n[1:0], addr[5:0], drv, val[17:0]}
  localparam logic [35:0] VEC [NV] = '{
    {4'd2, SEL,    1'b0, 1'b1, 2'b00, 6'h08, 1'b0, 18'h12345}, // R2 load write
    {4'd5, SEL,    1'b1, 1'b1, 2'b00, 6'h00, 1'b0, 18'h0AAAA}, // R5 burst write to 09
    {4'd1, SEL,    1'b0, 1'b0, 2'b00, 6'h08, 1'b1, 18'h12345}, // R1 read after write
    {4'd5, SEL,    1'b1, 1'b0, 2'b00, 6'h00, 1'b1, 18'h0AAAA}, // R5 burst read 09
    {4'd2, SEL,    1'b0, 1'b1, 2'b00, 6'h10, 1'b0, 18'h3FFFF}, // R2 write after read
    {4'd3, SEL,    1'b0, 1'b0, 2'b00, 6'h10, 1'b1, 18'h3FFFF}, // R3 forwarded read
    {4'd4, SEL,    1'b0, 1'b1, 2'b10, 6'h10, 1'b0, 18'h00000}, // R4 lane0 only
    {4'd4, SEL,    1'b0, 1'b0, 2'b00, 6'h10, 1'b1, 18'h3FE00}, // R4 merged forward
    {4'd7, 3'b011, 1'b0, 1'b1, 2'b00, 6'h08, 1'b0, 18'h00000}, // R7 deselected write
    {4'd8, SEL,    1'b1, 1'b0, 2'b00, 6'h00, 1'b0, 18'h00000}, // R8 dead continue
    {4'd7, SEL,    1'b0, 1'b0, 2'b00, 6'h08, 1'b1, 18'h12345}, // R7 word untouched
    {4'd4, SEL,    1'b0, 1'b1, 2'b01, 6'h09, 1'b0, 18'h3FFFF}, // R4 lane1 only
    {4'd3, SEL,    1'b0, 1'b0, 2'b00, 6'h09, 1'b1, 18'h3FEAA}, // R3 lane merge
    {4'd5, SEL,    1'b1, 1'b0, 2'b00, 6'h00, 1'b1, 18'h12345}  // R5 09^1 = 08
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sleep = 1'b0;
  logic              cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
  logic              adv = 1'b0, wr = 1'b0, lin = 1'b0, oe_n = 1'b0;
  logic [LANES-1:0]  bw_n = '1;
  logic [ADDR_W-1:0] addr = '0;
  logic              tb_en = 1'b1;
  logic [DW-1:0]     tb_d = '0;
  wire  [DW-1:0]     dq;
  int                n_run = 0, n_fail = 0;
  bit                done = 1'b0;

  assign dq = tb_en ? tb_d : {DW{1'bz}};

  always #2.5 clk = ~clk;

  zbs_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst(rst), .sleep(sleep), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .adv(adv), .wr(wr), .bw_n(bw_n), .addr(addr), .lin(lin), .oe_n(oe_n), .dq(dq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge: applies controls, then serves the bus for the
  // cycle after the capturing edge and checks it at the next falling edge.
  task automatic step(input logic [2:0] en, input logic a_adv, input logic a_wr,
                      input logic [1:0] a_bw, input logic [ADDR_W-1:0] a_addr,
                      input logic drv, input logic [DW-1:0] val, input string tag);
    {cs2_n, cs1, cs0_n} = en;
    adv = a_adv; wr = a_wr; bw_n = a_bw; addr = a_addr;
    @(posedge clk); #1;
    if (drv) tb_en = 1'b0;
    else begin tb_en = 1'b1; tb_d = val; end
    @(negedge clk);
    chk(tag, dq, val);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 bus idle in reset", dq, '0);
    rst = 1'b0;
    step(SEL, 1'b1, 1'b0, 2'b00, 6'h00, 1'b0, '0, "R8 continue after reset");

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      step(v[31:29], v[28], v[27], v[26:25], v[24:19], v[18], v[17:0],
           $sformatf("row %0d (R%0d)", i, v[35:32]));
    end

    // R7: each enable alone deselects a write; bench drives zeros after it
    step(3'b011, 1'b0, 1'b1, 2'b00, 6'h08, 1'b0, '0, "R7 cs0_n high");
    step(3'b000, 1'b0, 1'b1, 2'b00, 6'h08, 1'b0, '0, "R7 cs1 low");
    step(3'b110, 1'b0, 1'b1, 2'b00, 6'h08, 1'b0, '0, "R7 cs2_n high");
    step(SEL, 1'b0, 1'b0, 2'b00, 6'h08, 1'b1, 18'h12345, "R7 word kept");

    // R6 linear burst write from 0x21: 21,22,23,20
    lin = 1'b1;
    step(SEL, 1'b0, 1'b1, 2'b00, 6'h21, 1'b0, 18'h00001, "R6 lin w0");
    step(SEL, 1'b1, 1'b1, 2'b00, 6'h00, 1'b0, 18'h00002, "R6 lin w1");
    step(SEL, 1'b1, 1'b1, 2'b00, 6'h00, 1'b0, 18'h00003, "R6 lin w2");
    step(SEL, 1'b1, 1'b1, 2'b00, 6'h00, 1'b0, 18'h00004, "R6 lin w3");
    // R6 interleaved read from 0x21: 21,20,23,22
    lin = 1'b0;
    step(SEL, 1'b0, 1'b0, 2'b00, 6'h21, 1'b1, 18'h00001, "R6 ilv r0");
    step(SEL, 1'b1, 1'b0, 2'b00, 6'h00, 1'b1, 18'h00004, "R6 ilv r1");
    step(SEL, 1'b1, 1'b1, 2'b00, 6'h00, 1'b1, 18'h00003, "R5 wr ignored on continue");
    step(SEL, 1'b1, 1'b0, 2'b00, 6'h00, 1'b1, 18'h00002, "R6 ilv r3");
    // R6 linear read from 0x22: 22,23,20,21 then R5 wrap to 22
    lin = 1'b1;
    step(SEL, 1'b0, 1'b0, 2'b00, 6'h22, 1'b1, 18'h00002, "R6 lin r0");
    step(3'b011, 1'b1, 1'b0, 2'b00, 6'h3F, 1'b1, 18'h00003, "R5 enables ignored on continue");
    step(SEL, 1'b1, 1'b0, 2'b00, 6'h00, 1'b1, 18'h00004, "R6 lin r2");
    step(SEL, 1'b1, 1'b0, 2'b00, 6'h00, 1'b1, 18'h00001, "R6 lin r3");
    step(SEL, 1'b1, 1'b0, 2'b00, 6'h00, 1'b1, 18'h00002, "R5 counter wrap");
    lin = 1'b0;

    // R9: output enable high releases the bus; falling edge drives at once
    oe_n = 1'b1;
    step(SEL, 1'b0, 1'b0, 2'b00, 6'h08, 1'b0, '0, "R9 oe_n high released");
    tb_en = 1'b0;
    oe_n  = 1'b0;
    #1;
    chk("R9 oe_n low drives without clock", dq, 18'h12345);

    // R10: sleep holds burst state and blocks accesses
    step(SEL, 1'b0, 1'b0, 2'b00, 6'h08, 1'b1, 18'h12345, "R10 load before sleep");
    sleep = 1'b1;
    step(SEL, 1'b0, 1'b1, 2'b00, 6'h09, 1'b0, '0, "R10 write in sleep");
    step(SEL, 1'b1, 1'b0, 2'b00, 6'h00, 1'b0, '0, "R10 continue in sleep");
    sleep = 1'b0;
    step(SEL, 1'b1, 1'b0, 2'b00, 6'h00, 1'b1, 18'h3FEAA, "R10 burst resumes");
    step(SEL, 1'b0, 1'b0, 2'b00, 6'h09, 1'b1, 18'h3FEAA, "R10 array kept");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule